// File: doc/BRIEF.md
# Masked Vector Compress/Expand Unit

This unit rearranges the lanes of an N-lane vector under a per-lane predicate. In compress mode, every source lane whose predicate bit is set moves toward lane 0 and keeps its original relative order. All result lanes above the last kept element read zero. In expand mode, the unit does the reverse placement. Elements are taken one after another from the low end of the source vector and dropped into the lanes whose predicate bit is set. Lanes whose bit is clear read zero. Expanding a compressed vector with the same predicate returns the selected lanes to where they started.

One operation is accepted per cycle when `in_valid` is high. The result, a valid flag and the number of set predicate bits appear one clock later. The unit does not compare data to build the predicate, and it does not access memory. Lane k of every vector port occupies bits [k*W +: W].

A two-state controller qualifies the output. In ST_IDLE no result is presented. In ST_OUT the registered result is valid. The transitions are as follows. ST_IDLE goes to ST_OUT when `in_valid` is high. ST_OUT stays in ST_OUT when `in_valid` is high. ST_OUT returns to ST_IDLE when `in_valid` is low. ST_IDLE stays in ST_IDLE when `in_valid` is low.

Top module: `cx_unit`

## Requirements
- R1: With `op_mode`=0 (compress), each source lane i with `lane_mask[i]`=1 appears in the result at lane p, where p is the number of set bits below bit i. Kept elements therefore stay in their source order, starting from lane 0.
- R2: In compress mode, every result lane whose index is at least popcount(`lane_mask`) is zero.
- R3: With `op_mode`=1 (expand), result lane i with `lane_mask[i]`=1 receives source lane p, where p is the number of set bits below bit i. No source element is skipped or used twice.
- R4: In expand mode, every result lane i with `lane_mask[i]`=0 is zero.
- R5: An all-zero mask gives an all-zero result and a count of zero in both modes.
- R6: An all-ones mask gives a result equal to the source in both modes.
- R7: `active_count` equals the number of set bits of the `lane_mask` that produced the result.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high and low after a cycle with `in_valid` low. The result and count registers load only when `in_valid` is high.
- R9: Compressing a vector with a mask and then expanding the result with the same mask yields the source lanes where the mask is set and zero elsewhere.
- R10: While `rst_n` is low, and in the first cycle after it rises, `out_valid`, `result_flat` and `active_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation request this cycle |
| op_mode | input | 1 | 0 = compress, 1 = expand |
| lane_mask | input | N | Per-lane predicate |
| src_flat | input | N*W | Source vector, lane k at bits [k*W +: W] |
| out_valid | output | 1 | Registered result is valid |
| result_flat | output | N*W | Registered result vector |
| active_count | output | $clog2(N+1) | Popcount of the mask used for the result |

## Verification
A wrong running lane count inside the prefix logic shows up in the first result that uses it, one clock after the request. In compress mode it appears as duplicated, missing or shifted elements, or as non-zero data above the kept region. In expand mode it appears as a source element placed in the wrong lane. A wrong controller state appears on `out_valid` in the very next cycle. The compress-then-expand round trip on pseudo-random masks exposes any mismatch between the two placements at once, because any disagreement leaves a masked lane holding the wrong value.

// File: rtl/cx_pkg.sv
package cx_pkg;
    typedef enum logic {
        CX_COMPRESS = 1'b0,
        CX_EXPAND   = 1'b1
    } cx_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OUT  = 1'b1
    } cx_state_e;
endpackage

// File: rtl/cx_prefix.sv
// Exclusive running count of set mask bits per lane, plus the total.
module cx_prefix #(
    parameter int N  = 8,
    parameter int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]    mask,
    output logic [N*CW-1:0] prefix_flat,
    output logic [CW-1:0]   total
);
    logic [CW-1:0] run;

    always_comb begin
        run = '0;
        prefix_flat = '0;
        for (int i = 0; i < N; i++) begin
            prefix_flat[i*CW +: CW] = run;
            run = run + CW'(mask[i]);
        end
        total = run;
    end
endmodule

// File: rtl/cx_router.sv
// Per-lane selection for compress and expand placement.
module cx_router
    import cx_pkg::*;
#(
    parameter int N  = 8,
    parameter int W  = 32,
    parameter int CW = $clog2(N + 1)
) (
    input  cx_mode_e        mode,
    input  logic [N-1:0]    mask,
    input  logic [N*W-1:0]  src_flat,
    input  logic [N*CW-1:0] prefix_flat,
    output logic [N*W-1:0]  res_flat
);
    for (genvar j = 0; j < N; j++) begin : g_lane
        logic [W-1:0]  cmp_val;
        logic [W-1:0]  exp_val;
        logic [CW-1:0] my_pos;

        assign my_pos = prefix_flat[j*CW +: CW];

        // compress: gather the kept source lane whose rank equals j
        always_comb begin
            cmp_val = '0;
            for (int i = 0; i < N; i++) begin
                if (mask[i] && (prefix_flat[i*CW +: CW] == CW'(j)))
                    cmp_val = cmp_val | src_flat[i*W +: W];
            end
        end

        // expand: fetch the source lane indexed by this lane's rank
        always_comb begin
            exp_val = '0;
            if (mask[j]) begin
                for (int k = 0; k < N; k++) begin
                    if (my_pos == CW'(k))
                        exp_val = src_flat[k*W +: W];
                end
            end
        end

        assign res_flat[j*W +: W] = (mode == CX_EXPAND) ? exp_val : cmp_val;
    end
endmodule

// File: rtl/cx_unit.sv
module cx_unit
    import cx_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 32,
    localparam int CW = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           in_valid,
    input  logic           op_mode,
    input  logic [N-1:0]   lane_mask,
    input  logic [N*W-1:0] src_flat,
    output logic           out_valid,
    output logic [N*W-1:0] result_flat,
    output logic [CW-1:0]  active_count
);
    cx_state_e       state_q, state_d;
    cx_mode_e        mode_in;
    cx_mode_e        mode_q;
    logic [N-1:0]    mask_q;
    logic [N*CW-1:0] prefix_flat;
    logic [CW-1:0]   total;
    logic [N*W-1:0]  routed;

    assign mode_in = cx_mode_e'(op_mode);

    cx_prefix #(.N(N), .CW(CW)) u_prefix (
        .mask        (lane_mask),
        .prefix_flat (prefix_flat),
        .total       (total)
    );

    cx_router #(.N(N), .W(W), .CW(CW)) u_router (
        .mode        (mode_in),
        .mask        (lane_mask),
        .src_flat    (src_flat),
        .prefix_flat (prefix_flat),
        .res_flat    (routed)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_OUT;
            ST_OUT:  if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_flat  <= '0;
            active_count <= '0;
            mode_q       <= CX_COMPRESS;
            mask_q       <= '0;
        end else if (in_valid) begin
            result_flat  <= routed;
            active_count <= total;
            mode_q       <= mode_in;
            mask_q       <= lane_mask;
        end
    end

    assign out_valid = (state_q == ST_OUT);

    // ---------------- assertions ----------------
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_valid_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result_flat));
    a_r7_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (32'(active_count) == $countones($past(lane_mask))));
    a_r5_zero_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane_mask == '0) |=> (result_flat == '0));
    a_r6_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (&lane_mask)) |=> (result_flat == $past(src_flat)));

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r2_compress_zero_tail: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && mode_q == CX_COMPRESS && CW'(i) >= active_count)
                |-> (result_flat[i*W +: W] == '0));
        a_r4_expand_zero_gap: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && mode_q == CX_EXPAND && !mask_q[i])
                |-> (result_flat[i*W +: W] == '0));
    end
endmodule

// File: tb/cx_unit_tb.sv
module cx_unit_tb_top;
    localparam int N  = 8;
    localparam int W  = 32;
    localparam int CW = $clog2(N + 1);

    typedef struct packed {
        logic        mode;
        logic [7:0]  mask;
        logic [31:0] seed;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VTAB [NV] = '{
        '{1'b0, 8'hA5, 32'h1000_0000},
        '{1'b0, 8'h80, 32'h2000_0000},
        '{1'b0, 8'h01, 32'h3000_0000},
        '{1'b0, 8'h3C, 32'h4000_0000},
        '{1'b0, 8'hFE, 32'h5000_0000},
        '{1'b1, 8'hA5, 32'h6000_0000},
        '{1'b1, 8'h80, 32'h7000_0000},
        '{1'b1, 8'h01, 32'h8000_0000},
        '{1'b1, 8'h5A, 32'h9000_0000},
        '{1'b1, 8'h7F, 32'hA000_0000}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic           op_mode = 1'b0;
    logic [N-1:0]   lane_mask = '0;
    logic [N*W-1:0] src_flat = '0;
    logic           out_valid;
    logic [N*W-1:0] result_flat;
    logic [CW-1:0]  active_count;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    cx_unit #(.N(N), .W(W)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .op_mode      (op_mode),
        .lane_mask    (lane_mask),
        .src_flat     (src_flat),
        .out_valid    (out_valid),
        .result_flat  (result_flat),
        .active_count (active_count)
    );

    function automatic logic [N*W-1:0] ref_op(input logic mode, input logic [N-1:0] m,
                                              input logic [N*W-1:0] s);
        logic [N*W-1:0] r;
        int j;
        r = '0;
        j = 0;
        for (int i = 0; i < N; i++) begin
            if (m[i]) begin
                if (!mode) r[j*W +: W] = s[i*W +: W];
                else       r[i*W +: W] = s[j*W +: W];
                j++;
            end
        end
        return r;
    endfunction

    function automatic int pop(input logic [N-1:0] m);
        int c;
        c = 0;
        for (int i = 0; i < N; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [N*W-1:0] make_src(input logic [31:0] seed);
        logic [N*W-1:0] s;
        for (int i = 0; i < N; i++) s[i*W +: W] = seed + 32'h0101_0101 * (i + 1);
        return s;
    endfunction

    task automatic chk(input string tag, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    // drive one op at negedge, sample one cycle later at negedge
    task automatic apply(input logic mode, input logic [N-1:0] m, input logic [N*W-1:0] s);
        @(negedge clk);
        in_valid  = 1'b1;
        op_mode   = mode;
        lane_mask = m;
        src_flat  = s;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    task automatic apply_and_check(input string tag, input logic mode,
                                   input logic [N-1:0] m, input logic [N*W-1:0] s);
        apply(mode, m, s);
        chk({tag, " R8 valid"}, {{(N*W-1){1'b0}}, out_valid}, 1);
        chk({tag, " data"}, result_flat, ref_op(mode, m, s));
        chk({tag, " R7 count"}, (N*W)'(active_count), (N*W)'(pop(m)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [N*W-1:0] s;
        logic [N*W-1:0] packed_v;
        logic [N*W-1:0] keep;
        logic [31:0]    lfsr;

        // R10: reset state
        repeat (3) @(negedge clk);
        chk("R10 reset valid", (N*W)'(out_valid), '0);
        chk("R10 reset data", result_flat, '0);
        chk("R10 reset count", (N*W)'(active_count), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release valid", (N*W)'(out_valid), '0);

        // table walk: compress rows cover R1 R2, expand rows cover R3 R4
        for (int v = 0; v < NV; v++) begin
            apply_and_check(VTAB[v].mode ? "R3 R4 expand" : "R1 R2 compress",
                            VTAB[v].mode, VTAB[v].mask, make_src(VTAB[v].seed));
        end

        // R8: idle cycle drops valid and holds data
        s = result_flat;
        @(negedge clk);
        chk("R8 idle valid low", (N*W)'(out_valid), '0);
        chk("R8 idle hold", result_flat, s);

        // R5: empty mask, both modes
        apply_and_check("R5 compress", 1'b0, '0, make_src(32'hDEAD_0000));
        chk("R5 compress zero", result_flat, '0);
        apply_and_check("R5 expand", 1'b1, '0, make_src(32'hBEEF_0000));
        chk("R5 expand zero", result_flat, '0);

        // R6: full mask, both modes
        s = make_src(32'h0BAD_F00D);
        apply_and_check("R6 compress", 1'b0, '1, s);
        chk("R6 compress identity", result_flat, s);
        apply_and_check("R6 expand", 1'b1, '1, s);
        chk("R6 expand identity", result_flat, s);

        // back-to-back ops keep valid high
        @(negedge clk);
        in_valid = 1'b1; op_mode = 1'b0; lane_mask = 8'h0F; src_flat = make_src(32'h1111);
        @(negedge clk);
        chk("R8 back-to-back first", result_flat, ref_op(1'b0, 8'h0F, make_src(32'h1111)));
        op_mode = 1'b1; lane_mask = 8'hF0; src_flat = make_src(32'h2222);
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 back-to-back valid", (N*W)'(out_valid), 1);
        chk("R8 back-to-back second", result_flat, ref_op(1'b1, 8'hF0, make_src(32'h2222)));

        // R9: compress then expand round trip on pseudo-random masks
        lfsr = 32'hACE1_1234;
        for (int t = 0; t < 24; t++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            s = make_src(lfsr ^ 32'h5A5A_0000);
            apply(1'b0, lfsr[N-1:0], s);
            packed_v = result_flat;
            apply(1'b1, lfsr[N-1:0], packed_v);
            keep = '0;
            for (int i = 0; i < N; i++)
                if (lfsr[i]) keep[i*W +: W] = s[i*W +: W];
            chk("R9 round trip", result_flat, keep);
        end

        finish_run();
    end
endmodule